// File: doc/BRIEF.md
# Integer Condition-Code ALU

This block is a 32-bit integer execution unit. It computes a sum, a difference, a sum with an incoming carry, or a bitwise AND, OR or XOR of two operands. It can also record a four-bit condition-code word describing that result. A branch unit elsewhere in the pipeline reads the word as negative (N), zero (Z), signed overflow (V) and carry/borrow (C). The condition codes change only when the caller asks for them with the set-cc input. Any other operation leaves them untouched while it still delivers its result.

Both the result and the condition codes are registered. Each one appears on the clock edge after its inputs are sampled. An add-with-carry in the next cycle therefore sees the carry produced by the add just before it. This lets a 64-bit sum be built as a low-word add followed by a high-word add-with-carry. A compare is an ordinary subtract with set-cc high whose result the caller ignores. A test is an OR with a zero operand and set-cc high.

Top module: `icc_alu`

## Requirements
- R1: Operation code 0 (add) yields `src_a + src_b` modulo 2^32. With set-cc high, C becomes the carry out of bit 31 and V is set when two operands of equal sign give a result of the other sign.
- R2: Operation code 1 (subtract) yields `src_a - src_b` modulo 2^32. With set-cc high, C becomes 1 exactly when `src_a < src_b` as unsigned numbers (a borrow). V is set when the operands differ in sign and the result's sign differs from `src_a`.
- R3: Operation code 2 (add with carry) yields `src_a + src_b + C`, where C is the current registered carry flag. Its C and V follow the add rules. A code-0 add with set-cc, followed next cycle by a code-2 add with set-cc on the upper words, gives the correct 64-bit sum.
- R4: Operation codes 3, 4 and 5 yield AND, OR and XOR. With set-cc high they clear V and C.
- R5: For every cc-setting operation with codes 0 to 5, N equals bit 31 of the new result and Z is 1 exactly when the new result is all zeros.
- R6: With set-cc low, the flag register keeps its value while `res_q` still takes the new result.
- R7: While reset is high, the next clock edge drives `res_q` to 0 and the flags to 0000.
- R8: The result and flags for inputs sampled at one rising edge are visible after that edge, one cycle of latency, with no combinational path from inputs to outputs.
- R9: Operation codes 6 and 7 are reserved. They drive `res_q` to 0 and leave the flags unchanged, whatever set-cc is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 add with carry, 3 AND, 4 OR, 5 XOR, 6-7 reserved |
| set_cc | input | 1 | When high, the operation also updates the flags |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| res_q | output | 32 | Registered result |
| flags_q | output | 4 | Registered flags: bit 3 N, bit 2 Z, bit 1 V, bit 0 C |

## Verification
The bench aims at the edges of each flag rule. It adds all-ones and one, which must give a zero result with Z and C set. It adds and subtracts across the positive/negative boundary: a unit that inverted the overflow test or used the add rule on a subtract would report V wrongly. It subtracts a larger value from a smaller one: a carry flag that kept its adder meaning would show the inverse of a borrow. It chains a low and a high word to check that the add-with-carry uses the registered carry, not a stale or zero value. It issues cc-free and reserved operations after known flag states, so a unit that updated the flags anyway would show changed flags at the next edge.

// File: rtl/icc_pkg.sv
`timescale 1ns/1ps
package icc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDC = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    LF_AND = 2'd0,
    LF_OR  = 2'd1,
    LF_XOR = 2'd2
  } lfn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;
endpackage

// File: rtl/icc_arith.sv
`timescale 1ns/1ps
module icc_arith #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cflag,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic         c_in_eff;
  logic         c_out;

  always_comb begin
    b_eff    = sub ? ~b : b;
    c_in_eff = sub ? 1'b1 : cin;
    {c_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_in_eff};
    // after subtract the flag reports a borrow, the inverse of the adder carry
    cflag = sub ? ~c_out : c_out;
    ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/icc_logic.sv
`timescale 1ns/1ps
module icc_logic
  import icc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lfn_e         fn,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (fn)
        LF_AND:  y[i] = a[i] & b[i];
        LF_OR:   y[i] = a[i] | b[i];
        default: y[i] = a[i] ^ b[i];
      endcase
    end
  end
endmodule

// File: rtl/icc_flags.sv
`timescale 1ns/1ps
module icc_flags
  import icc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic upd,
  input  cc_t  nxt,
  output cc_t  cur
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (upd) cur <= nxt;
    end
  end

  // R6: without an update request the stored word must not move
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(upd)) |-> (cur == $past(cur)));
endmodule

// File: rtl/icc_alu.sv
`timescale 1ns/1ps
module icc_alu
  import icc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_sel,
  input  logic         set_cc,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic [W-1:0] res_q,
  output logic [3:0]   flags_q
);
  localparam logic [2:0] LAST_VALID = 3'd5;

  logic         is_sub, is_addc, is_arith, is_logic, op_ok;
  lfn_e         lfn;
  logic [W-1:0] arith_y, logic_y, res_d;
  logic         arith_c, arith_v;
  cc_t          cc_cur, cc_nxt;

  always_comb begin
    is_sub   = (op_sel == OP_SUB);
    is_addc  = (op_sel == OP_ADDC);
    is_arith = (op_sel == OP_ADD) || is_sub || is_addc;
    is_logic = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR);
    op_ok    = is_arith || is_logic;
    unique case (op_sel)
      OP_AND:  lfn = LF_AND;
      OP_OR:   lfn = LF_OR;
      default: lfn = LF_XOR;
    endcase
  end

  icc_arith #(.W(W)) u_arith (
    .a(src_a), .b(src_b), .cin(is_addc & cc_cur.c), .sub(is_sub),
    .sum(arith_y), .cflag(arith_c), .ovf(arith_v)
  );

  icc_logic #(.W(W)) u_logic (
    .a(src_a), .b(src_b), .fn(lfn), .y(logic_y)
  );

  always_comb begin
    if (is_arith)      res_d = arith_y;
    else if (is_logic) res_d = logic_y;
    else               res_d = '0;
    cc_nxt.n = res_d[W-1];
    cc_nxt.z = (res_d == '0);
    cc_nxt.v = is_arith & arith_v;
    cc_nxt.c = is_arith & arith_c;
  end

  icc_flags u_flags (
    .clk(clk), .rst(rst), .upd(set_cc & op_ok), .nxt(cc_nxt), .cur(cc_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) res_q <= '0;
    else     res_q <= res_d;
  end

  assign flags_q = cc_cur;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (res_q == '0 && flags_q == 4'b0000));

  assert_sign_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(set_cc) && $past(op_sel) <= LAST_VALID) |-> (flags_q[3] == res_q[W-1]));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(set_cc) && $past(op_sel) <= LAST_VALID) |-> (flags_q[2] == (res_q == '0)));

  assert_borrow_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(set_cc) && $past(op_sel) == OP_SUB) |-> (flags_q[0] == ($past(src_a) < $past(src_b))));

  assert_logic_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(set_cc) && $past(op_sel) >= 3'd3 && $past(op_sel) <= LAST_VALID)
      |-> (flags_q[1:0] == 2'b00));

  assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_sel) > LAST_VALID) |-> (res_q == '0 && flags_q == $past(flags_q)));
endmodule

// File: tb/sim_icc_alu.sv
`timescale 1ns/1ps
module sim_icc_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_sel = 3'd0;
  logic        set_cc = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] res_q;
  logic [3:0]  flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] m_flags = 4'b0000;

  always #2 clk = ~clk;

  icc_alu #(.W(32)) u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .set_cc(set_cc),
    .src_a(src_a), .src_b(src_b), .res_q(res_q), .flags_q(flags_q)
  );

  function automatic void model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [3:0] f, output logic [31:0] r, output logic [3:0] nf);
    longint sa, sb, ss;
    longint unsigned us;
    logic v, c;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    v = 1'b0; c = 1'b0; r = '0; us = 0; ss = 0;
    case (op)
      3'd0: begin us = {32'b0, a} + {32'b0, b}; ss = sa + sb; end
      3'd1: begin us = {32'b0, a - b}; ss = sa - sb; end
      3'd2: begin us = {32'b0, a} + {32'b0, b} + {63'b0, f[0]}; ss = sa + sb + longint'(f[0]); end
      default: ;
    endcase
    case (op)
      3'd0, 3'd2: begin r = us[31:0]; c = (us > 64'hFFFF_FFFF); end
      3'd1: begin r = us[31:0]; c = (a < b); end
      3'd3: r = a & b;
      3'd4: r = a | b;
      3'd5: r = a ^ b;
      default: r = '0;
    endcase
    if (op <= 3'd2) v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    nf = {r[31], (r == 32'd0), v, c};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic cc, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    logic [31:0] er;
    logic [3:0]  ef;
    @(negedge clk);
    op_sel = op; set_cc = cc; src_a = a; src_b = b;
    model(op, a, b, m_flags, er, ef);
    if (!cc || op > 3'd5) ef = m_flags;
    @(posedge clk);
    #1;
    check({tag, " result"}, res_q, er);
    check({tag, " flags"}, {28'b0, flags_q}, {28'b0, ef});
    m_flags = ef;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op_sel = 3'd0; set_cc = 1'b1; src_a = 32'h1234; src_b = 32'h1;
    @(posedge clk); #1;
    check("R7 reset result", res_q, 32'd0);
    check("R7 reset flags", {28'b0, flags_q}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    m_flags = 4'b0000;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lo_sum, hi_sum;
    repeat (3) @(posedge clk);
    do_reset();

    // R1 add corners: wrap to zero with carry, positive overflow
    step(3'd0, 1'b1, 32'hFFFF_FFFF, 32'h1, "R1 R5 R8 add wrap");
    step(3'd0, 1'b1, 32'h7FFF_FFFF, 32'h1, "R1 add ovf");
    step(3'd0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R1 add neg ovf");
    step(3'd0, 1'b1, 32'd100, 32'd23, "R1 add plain");
    // R2 subtract and compare
    step(3'd1, 1'b1, 32'd3, 32'd5, "R2 sub borrow");
    step(3'd1, 1'b1, 32'd42, 32'd42, "R2 R5 compare equal");
    step(3'd1, 1'b1, 32'h8000_0000, 32'h1, "R2 sub ovf");
    step(3'd1, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R2 sub ovf2");
    step(3'd1, 1'b1, 32'd9, 32'd2, "R2 sub no borrow");
    // R3 64-bit chain: 0x00000001_FFFFFFFF + 0x00000002_00000001
    step(3'd0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, "R3 low word");
    lo_sum = res_q;
    step(3'd2, 1'b1, 32'h0000_0001, 32'h0000_0002, "R3 high word");
    hi_sum = res_q;
    check("R3 64-bit sum hi", hi_sum, 32'h0000_0004);
    check("R3 64-bit sum lo", lo_sum, 32'h0000_0000);
    step(3'd2, 1'b1, 32'h7FFF_FFFF, 32'h0, "R3 addc no carry");
    // R4 logic with cc after flags set with V and C
    step(3'd1, 1'b1, 32'h8000_0000, 32'h1, "R2 setup");
    step(3'd3, 1'b1, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R4 and zero");
    step(3'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 setup");
    step(3'd4, 1'b1, 32'h8000_0001, 32'h0, "R4 test neg");
    step(3'd5, 1'b1, 32'hAAAA_5555, 32'h5555_AAAA, "R4 xor");
    // R6 set_cc low keeps flags, result still produced
    step(3'd1, 1'b1, 32'd1, 32'd2, "R6 setup");
    step(3'd0, 1'b0, 32'd0, 32'd0, "R6 hold add");
    step(3'd4, 1'b0, 32'h1, 32'h2, "R6 hold or");
    // R9 reserved codes
    step(3'd6, 1'b1, 32'h1234_5678, 32'h1, "R9 code6");
    step(3'd7, 1'b0, 32'hFFFF_FFFF, 32'h1, "R9 code7");
    // mid-run reset
    do_reset();

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom();
      b = $urandom();
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 32'h8000_0000;
      if (i % 13 == 0) b = 32'hFFFF_FFFF;
      step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), a, b, "R1 R2 R3 R4 R6 R9 mixed");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule